// File: doc/BRIEF.md
# Control Register Write Checker

This block holds the three architectural control words of a paged processor core: a system control word, a page-table base word and an extension control word. It accepts one move-to-control-register request at a time. Each request is checked against the execution mode, the privilege level and the legal combinations of flag bits. The request then either updates the selected word or raises a protection fault. A faulted request leaves every word unchanged, and all such faults carry error code zero.

A committed write that flips a paging-related flag also raises a pulse asking the translation cache to drop every entry, global ones included. Some writes turn on the wide-address paging scheme while paging is active. Those writes first fetch a four-entry table of 64-bit pointers from memory at the page-table base, using a request/valid handshake. The write and the new table take effect together only if every fetched entry is free of reserved bits. Otherwise the write ends in a fault and nothing changes.

Top module: `ctlreg_write_unit`

## Requirements
- R1: After reset the system word reads 0x6000_0010, the base word, the extension word and all four table entries read zero, and busy, commit, fault, tlb_flush_all and mem_req are low.
- R2: A request accepted with mode 2 or 3 (virtual-8086) always faults, one cycle after acceptance, with no commit and no register change.
- R3: In protected mode (mode 1), a request with cpl other than 0 faults and changes nothing.
- R4: In protected mode, a write to the system word (select 0) faults in two cases: bit 31 (paging enable) is 1 while bit 0 (protection enable) is 0, or bit 30 (cache disable) is 0 while bit 5 (numeric-error enable) is 1. Real mode (mode 0) does not apply these two checks.
- R5: A write to the extension word (select 2) that sets any bit in the reserved mask (default bits 31..11) faults in both real and protected mode. Real mode ignores cpl.
- R6: Select value 3 names no register, and a request with it always faults.
- R7: A legal write that needs no table reload updates the selected word and pulses commit one cycle after acceptance.
- R8: tlb_flush_all pulses together with commit exactly when the committed write changes bit 0 or bit 31 of the system word, or bit 4, 5 or 7 of the extension word. A write to the base word never flushes.
- R9: A table reload starts in three cases. A select-2 write takes bit 5 from 0 to 1 while system bit 31 is 1. A select-1 write arrives while extension bit 5 and system bit 31 are both 1. A select-0 write takes bit 31 from 0 to 1 while extension bit 5 is 1. On a reload, busy rises one cycle after acceptance. The block then reads entries 0..3 in order from the 32-byte-aligned base plus 8 times the index, with the base taken from the new value on a select-1 write. It holds mem_req and mem_addr until mem_valid.
- R10: If all four fetched entries are clean, the staged write, the new table (entry k at ptr_table bits 64k+63..64k) and any flush from R8 take effect with a commit pulse in the cycle after the last entry's flush-free completion, and busy falls.
- R11: If any fetched entry has a bit set in the entry reserved mask (default bits 1, 2, 5..8 and 63..36), the request faults instead. The registers and the table stay unchanged.
- R12: A request presented while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Move request present |
| wr_sel | input | 2 | Target: 0 system, 1 base, 2 extension, 3 none |
| wr_data | input | 32 | Value to write |
| cpl | input | 2 | Current privilege level |
| mode | input | 2 | 0 real, 1 protected, 2 or 3 virtual-8086 |
| busy | output | 1 | Table reload in progress; requests ignored |
| commit | output | 1 | One-cycle pulse: write took effect |
| fault | output | 1 | One-cycle pulse: protection fault, code 0 |
| tlb_flush_all | output | 1 | One-cycle pulse: drop all translations incl. global |
| mem_req | output | 1 | Table entry read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_valid | input | 1 | Read data present this cycle |
| mem_data | input | 64 | Read data |
| sys_ctl | output | 32 | System control word |
| page_base | output | 32 | Page-table base word |
| ext_ctl | output | 32 | Extension control word |
| ptr_table | output | 256 | Installed pointer table, four 64-bit entries |

## Verification
The assertions assume that mem_valid is raised only while mem_req is high, and that wr_sel, wr_data, cpl and mode are known whenever wr_valid is high. They also assume the memory side answers each request eventually. The bench drives mem_valid only at negative edges where it sees mem_req. It stalls every other cycle to exercise the hold rule. It sweeps every mode, privilege level and select value against a fixed set of data words, so the request fields are always defined.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    typedef enum logic [1:0] {
        SEL_SYS  = 2'd0,
        SEL_BASE = 2'd1,
        SEL_EXT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam logic [1:0] MODE_REAL = 2'd0;
    localparam logic [1:0] MODE_PROT = 2'd1;

    localparam int SYS_PROT_BIT     = 0;
    localparam int SYS_NUMERR_BIT   = 5;
    localparam int SYS_CACHEOFF_BIT = 30;
    localparam int SYS_PAGING_BIT   = 31;
    localparam int EXT_LARGEPG_BIT  = 4;
    localparam int EXT_WIDEADDR_BIT = 5;
    localparam int EXT_GLOBALPG_BIT = 7;

    localparam logic [31:0] SYS_FLUSH_FLAGS =
        (32'd1 << SYS_PROT_BIT) | (32'd1 << SYS_PAGING_BIT);
    localparam logic [31:0] EXT_FLUSH_FLAGS =
        (32'd1 << EXT_LARGEPG_BIT) | (32'd1 << EXT_WIDEADDR_BIT) |
        (32'd1 << EXT_GLOBALPG_BIT);

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FETCH = 2'd1,
        LD_DONE  = 2'd2
    } ld_state_e;

endpackage

// File: rtl/ctlreg_legality.sv
module ctlreg_legality
    import ctlreg_pkg::*;
#(
    parameter logic [31:0] EXT_RSVD_MASK = 32'hFFFF_F800
) (
    input  logic [1:0]  sel_i,
    input  logic [31:0] data_i,
    input  logic [1:0]  cpl_i,
    input  logic [1:0]  mode_i,
    input  logic [31:0] sys_i,
    input  logic [31:0] ext_i,
    output logic        fault_o,
    output logic        reload_o,
    output logic        flush_o
);

    logic        in_v86;
    logic        in_prot;
    logic        sys_combo_bad;
    logic        ext_rsvd_hit;
    logic [31:0] sys_next;
    logic [31:0] ext_next;

    always_comb begin
        in_v86   = mode_i[1];
        in_prot  = (mode_i == MODE_PROT);

        sys_combo_bad = (data_i[SYS_PAGING_BIT] && !data_i[SYS_PROT_BIT]) ||
                        (!data_i[SYS_CACHEOFF_BIT] && data_i[SYS_NUMERR_BIT]);
        ext_rsvd_hit  = |(data_i & EXT_RSVD_MASK);

        // priority: mode, then privilege, then bit legality
        if (in_v86)
            fault_o = 1'b1;
        else if (in_prot && cpl_i != 2'd0)
            fault_o = 1'b1;
        else if (sel_i == SEL_NONE)
            fault_o = 1'b1;
        else if (sel_i == SEL_SYS)
            fault_o = in_prot && sys_combo_bad;
        else if (sel_i == SEL_EXT)
            fault_o = ext_rsvd_hit;
        else
            fault_o = 1'b0;

        sys_next = (sel_i == SEL_SYS) ? data_i : sys_i;
        ext_next = (sel_i == SEL_EXT) ? data_i : ext_i;

        flush_o = (|((sys_next ^ sys_i) & SYS_FLUSH_FLAGS)) ||
                  (|((ext_next ^ ext_i) & EXT_FLUSH_FLAGS));

        reload_o = ((sel_i == SEL_EXT) && sys_i[SYS_PAGING_BIT] &&
                    !ext_i[EXT_WIDEADDR_BIT] && data_i[EXT_WIDEADDR_BIT]) ||
                   ((sel_i == SEL_BASE) && sys_i[SYS_PAGING_BIT] &&
                    ext_i[EXT_WIDEADDR_BIT]) ||
                   ((sel_i == SEL_SYS) && ext_i[EXT_WIDEADDR_BIT] &&
                    !sys_i[SYS_PAGING_BIT] && data_i[SYS_PAGING_BIT]);
    end

endmodule

// File: rtl/ctlreg_ptr_loader.sv
module ctlreg_ptr_loader
    import ctlreg_pkg::*;
#(
    parameter int          ENTRIES   = 4,
    parameter int          ADDR_W    = 32,
    parameter logic [63:0] RSVD_MASK = 64'hFFFF_FFF0_0000_01E6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        base_i,
    output logic                     mem_req_o,
    output logic [ADDR_W-1:0]        mem_addr_o,
    input  logic                     mem_valid_i,
    input  logic [63:0]              mem_data_i,
    output logic                     done_o,
    output logic                     bad_o,
    output logic [ENTRIES-1:0][63:0] entries_o
);

    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int ALIGN_W = $clog2(ENTRIES * 8);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        ld_state_e                state;
        logic [IDX_W-1:0]         idx;
        logic [ADDR_W-1:0]        base;
        logic [ENTRIES-1:0][63:0] ents;
        logic                     bad;
    } ld_regs_t;

    ld_regs_t ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        case (ld_q.state)
            LD_IDLE: begin
                if (start_i) begin
                    ld_d.state = LD_FETCH;
                    ld_d.idx   = '0;
                    ld_d.bad   = 1'b0;
                    ld_d.base  = {base_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
                end
            end
            LD_FETCH: begin
                if (mem_valid_i) begin
                    ld_d.ents[ld_q.idx] = mem_data_i;
                    ld_d.bad = ld_q.bad || (|(mem_data_i & RSVD_MASK));
                    if (ld_q.idx == LAST_IDX)
                        ld_d.state = LD_DONE;
                    else
                        ld_d.idx = ld_q.idx + 1'b1;
                end
            end
            LD_DONE:  ld_d.state = LD_IDLE;
            default:  ld_d.state = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q.state <= LD_IDLE;
            ld_q.idx   <= '0;
            ld_q.base  <= '0;
            ld_q.ents  <= '0;
            ld_q.bad   <= 1'b0;
        end else begin
            ld_q <= ld_d;
        end
    end

    assign mem_req_o  = (ld_q.state == LD_FETCH);
    assign mem_addr_o = ld_q.base + ADDR_W'({ld_q.idx, 3'b000});
    assign done_o     = (ld_q.state == LD_DONE);
    assign bad_o      = ld_q.bad;
    assign entries_o  = ld_q.ents;

    // R9: an unanswered request keeps its address until the data arrives
    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

    // R12: a new fetch is never started over one in flight
    a_r12_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> ld_q.state == LD_IDLE);

endmodule

// File: rtl/ctlreg_write_unit.sv
module ctlreg_write_unit
    import ctlreg_pkg::*;
#(
    parameter logic [31:0] SYS_RESET     = 32'h6000_0010,
    parameter logic [31:0] EXT_RSVD_MASK = 32'hFFFF_F800,
    parameter logic [63:0] PTR_RSVD_MASK = 64'hFFFF_FFF0_0000_01E6,
    parameter int          PTR_ENTRIES   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [1:0]                wr_sel,
    input  logic [31:0]               wr_data,
    input  logic [1:0]                cpl,
    input  logic [1:0]                mode,
    output logic                      busy,
    output logic                      commit,
    output logic                      fault,
    output logic                      tlb_flush_all,
    output logic                      mem_req,
    output logic [31:0]               mem_addr,
    input  logic                      mem_valid,
    input  logic [63:0]               mem_data,
    output logic [31:0]               sys_ctl,
    output logic [31:0]               page_base,
    output logic [31:0]               ext_ctl,
    output logic [PTR_ENTRIES*64-1:0] ptr_table
);

    typedef struct packed {
        logic [31:0]                  sys;
        logic [31:0]                  base;
        logic [31:0]                  ext;
        logic [PTR_ENTRIES-1:0][63:0] tbl;
        logic                         pending;
        logic [1:0]                   stg_sel;
        logic [31:0]                  stg_data;
        logic                         stg_flush;
        logic                         commit;
        logic                         fault;
        logic                         flush;
    } unit_regs_t;

    unit_regs_t u_d, u_q;

    logic                         accept;
    logic                         chk_fault;
    logic                         chk_reload;
    logic                         chk_flush;
    logic                         ld_start;
    logic [31:0]                  ld_base;
    logic                         ld_done;
    logic                         ld_bad;
    logic [PTR_ENTRIES-1:0][63:0] ld_entries;

    ctlreg_legality #(
        .EXT_RSVD_MASK(EXT_RSVD_MASK)
    ) u_legality (
        .sel_i   (wr_sel),
        .data_i  (wr_data),
        .cpl_i   (cpl),
        .mode_i  (mode),
        .sys_i   (u_q.sys),
        .ext_i   (u_q.ext),
        .fault_o (chk_fault),
        .reload_o(chk_reload),
        .flush_o (chk_flush)
    );

    ctlreg_ptr_loader #(
        .ENTRIES  (PTR_ENTRIES),
        .ADDR_W   (32),
        .RSVD_MASK(PTR_RSVD_MASK)
    ) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (ld_start),
        .base_i     (ld_base),
        .mem_req_o  (mem_req),
        .mem_addr_o (mem_addr),
        .mem_valid_i(mem_valid),
        .mem_data_i (mem_data),
        .done_o     (ld_done),
        .bad_o      (ld_bad),
        .entries_o  (ld_entries)
    );

    assign accept   = wr_valid && !u_q.pending;
    assign ld_start = accept && !chk_fault && chk_reload;
    assign ld_base  = (wr_sel == SEL_BASE) ? wr_data : u_q.base;

    always_comb begin
        u_d        = u_q;
        u_d.commit = 1'b0;
        u_d.fault  = 1'b0;
        u_d.flush  = 1'b0;

        if (accept) begin
            if (chk_fault) begin
                u_d.fault = 1'b1;
            end else if (chk_reload) begin
                u_d.pending   = 1'b1;
                u_d.stg_sel   = wr_sel;
                u_d.stg_data  = wr_data;
                u_d.stg_flush = chk_flush;
            end else begin
                case (wr_sel)
                    SEL_SYS:  u_d.sys  = wr_data;
                    SEL_BASE: u_d.base = wr_data;
                    SEL_EXT:  u_d.ext  = wr_data;
                    default:  u_d.sys  = u_q.sys;
                endcase
                u_d.commit = 1'b1;
                u_d.flush  = chk_flush;
            end
        end

        if (ld_done) begin
            u_d.pending = 1'b0;
            if (ld_bad) begin
                u_d.fault = 1'b1;
            end else begin
                case (u_q.stg_sel)
                    SEL_SYS:  u_d.sys  = u_q.stg_data;
                    SEL_BASE: u_d.base = u_q.stg_data;
                    SEL_EXT:  u_d.ext  = u_q.stg_data;
                    default:  u_d.sys  = u_q.sys;
                endcase
                u_d.tbl    = ld_entries;
                u_d.commit = 1'b1;
                u_d.flush  = u_q.stg_flush;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_q.sys       <= SYS_RESET;
            u_q.base      <= '0;
            u_q.ext       <= '0;
            u_q.tbl       <= '0;
            u_q.pending   <= 1'b0;
            u_q.stg_sel   <= SEL_NONE;
            u_q.stg_data  <= '0;
            u_q.stg_flush <= 1'b0;
            u_q.commit    <= 1'b0;
            u_q.fault     <= 1'b0;
            u_q.flush     <= 1'b0;
        end else begin
            u_q <= u_d;
        end
    end

    assign busy          = u_q.pending;
    assign commit        = u_q.commit;
    assign fault         = u_q.fault;
    assign tlb_flush_all = u_q.flush;
    assign sys_ctl       = u_q.sys;
    assign page_base     = u_q.base;
    assign ext_ctl       = u_q.ext;
    assign ptr_table     = u_q.tbl;

    // R2: virtual-8086 requests always end in a fault
    a_r2_v86_faults: assert property (@(posedge clk) disable iff (!rst_n)
        accept && mode[1] |=> fault && !commit);

    // R3: unprivileged protected-mode requests fault
    a_r3_priv_faults: assert property (@(posedge clk) disable iff (!rst_n)
        accept && mode == MODE_PROT && cpl != 2'd0 |=> fault);

    // R11: a fault leaves every architectural word and the table untouched
    a_r11_fault_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $stable(sys_ctl) && $stable(page_base) &&
                  $stable(ext_ctl) && $stable(ptr_table));

    // R8: a flush only accompanies a commit
    a_r8_flush_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_all |-> commit && !fault);

    // R9: memory is only requested during a reload
    a_r9_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R12: while a reload runs nothing resolves until the loader finishes
    a_r12_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !ld_done |=> !commit && !fault);

endmodule

// File: tb/tb_ctlreg_write_unit.sv
`timescale 1ns/1ps
module tb_ctlreg_write_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [31:0]  wr_data = 32'd0;
    logic [1:0]   cpl = 2'd0;
    logic [1:0]   mode = 2'd0;
    logic         busy, commit, fault, tlb_flush_all, mem_req;
    logic [31:0]  mem_addr;
    logic         mem_valid = 1'b0;
    logic [63:0]  mem_data = 64'd0;
    logic [31:0]  sys_ctl, page_base, ext_ctl;
    logic [255:0] ptr_table;

    always #2.5 clk = ~clk;

    ctlreg_write_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
        .wr_data(wr_data), .cpl(cpl), .mode(mode), .busy(busy),
        .commit(commit), .fault(fault), .tlb_flush_all(tlb_flush_all),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_data(mem_data), .sys_ctl(sys_ctl), .page_base(page_base),
        .ext_ctl(ext_ctl), .ptr_table(ptr_table)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0]  exp_sys, exp_base, exp_ext;
    logic [255:0] exp_tbl;
    int           poison_idx = -1;
    bit           inject_busy = 1'b0;
    bit           stall_tog = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_val(input logic [31:0] addr, input int k);
        logic [63:0] v;
        v = {28'h0, 4'(k), addr[31:12], 12'h001};
        if (k == poison_idx) v = v | 64'h2;
        return v;
    endfunction

    task automatic check_regs(input string req);
        chk(req, "sys_ctl", {32'h0, sys_ctl}, {32'h0, exp_sys});
        chk(req, "page_base", {32'h0, page_base}, {32'h0, exp_base});
        chk(req, "ext_ctl", {32'h0, ext_ctl}, {32'h0, exp_ext});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_valid = 1'b0;
        mem_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_sys = 32'h6000_0010;
        exp_base = 32'h0;
        exp_ext = 32'h0;
        exp_tbl = '0;
        // R1: reset state
        check_regs("R1");
        chk("R1", "ptr_table_zero", {63'h0, ptr_table == 256'h0}, 64'h1);
        chk("R1", "pulses_idle", {59'h0, busy, commit, fault, tlb_flush_all, mem_req}, 64'h0);
    endtask

    // serve the table fetch; returns the number of entries delivered
    task automatic serve(input logic [31:0] base, output int delivered);
        int k = 0;
        int guard = 0;
        logic [31:0] abase;
        abase = {base[31:5], 5'b0};
        while (busy && guard < 200) begin
            if (mem_req) begin
                chk("R9", "mem_addr", {32'h0, mem_addr}, {32'h0, abase + 32'(k * 8)});
                stall_tog = ~stall_tog;
                if (stall_tog) begin
                    mem_valid = 1'b1;
                    mem_data = entry_val(mem_addr, k);
                    if (k < 4) exp_tbl[k*64 +: 64] = entry_val(mem_addr, k);
                    k++;
                end else begin
                    mem_valid = 1'b0;
                end
            end else begin
                mem_valid = 1'b0;
            end
            if (inject_busy) begin
                // R12: this request arrives while busy and must be ignored
                chk("R12", "no_pulse_busy", {62'h0, commit, fault}, 64'h0);
                wr_valid = 1'b1;
                wr_sel = 2'd2;
                wr_data = 32'h0000_0090;
                cpl = 2'd0;
                mode = 2'd1;
            end
            @(negedge clk);
            wr_valid = 1'b0;
            mem_valid = 1'b0;
            guard++;
        end
        delivered = k;
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [31:0] d,
                            input logic [1:0] c, input logic [1:0] m);
        bit f, rl, fl, bad;
        string tag;
        logic [31:0] ns, nb, ne;
        logic [255:0] old_tbl;
        int got;
        f = 1'b0;
        tag = "R7";
        if (m[1]) begin f = 1'b1; tag = "R2"; end
        else if (m == 2'd1 && c != 2'd0) begin f = 1'b1; tag = "R3"; end
        else if (sel == 2'd3) begin f = 1'b1; tag = "R6"; end
        else if (sel == 2'd0 && m == 2'd1 &&
                 ((d[31] && !d[0]) || (!d[30] && d[5]))) begin f = 1'b1; tag = "R4"; end
        else if (sel == 2'd2 && (d & 32'hFFFF_F800) != 0) begin f = 1'b1; tag = "R5"; end
        ns = (sel == 2'd0) ? d : exp_sys;
        nb = (sel == 2'd1) ? d : exp_base;
        ne = (sel == 2'd2) ? d : exp_ext;
        fl = (((ns ^ exp_sys) & 32'h8000_0001) != 0) ||
             (((ne ^ exp_ext) & 32'h0000_00B0) != 0);
        rl = (sel == 2'd2 && exp_sys[31] && !exp_ext[5] && d[5]) ||
             (sel == 2'd1 && exp_sys[31] && exp_ext[5]) ||
             (sel == 2'd0 && exp_ext[5] && !exp_sys[31] && d[31]);

        @(negedge clk);
        wr_valid = 1'b1; wr_sel = sel; wr_data = d; cpl = c; mode = m;
        @(negedge clk);
        wr_valid = 1'b0;

        if (!f && rl) begin
            chk("R9", "busy_after_accept", {61'h0, busy, commit, fault}, 64'h4);
            old_tbl = exp_tbl;
            serve(nb, got);
            chk("R9", "entries_fetched", 64'(got), 64'd4);
            bad = (poison_idx >= 0);
            if (bad) begin
                exp_tbl = old_tbl;
                chk("R11", "fault_on_bad_entry", {61'h0, fault, commit, tlb_flush_all}, 64'h4);
            end else begin
                exp_sys = ns; exp_base = nb; exp_ext = ne;
                chk("R10", "commit_after_load", {61'h0, fault, commit, tlb_flush_all},
                    {61'h0, 1'b0, 1'b1, fl});
            end
            chk(bad ? "R11" : "R10", "busy_cleared", {63'h0, busy}, 64'h0);
            check_regs(bad ? "R11" : "R10");
            for (int i = 0; i < 4; i++)
                chk(bad ? "R11" : "R10", "ptr_entry",
                    ptr_table[i*64 +: 64], exp_tbl[i*64 +: 64]);
        end else begin
            if (!f) begin
                exp_sys = ns; exp_base = nb; exp_ext = ne;
            end
            chk(tag, "fault_commit", {62'h0, fault, commit}, {62'h0, f, !f});
            chk("R8", "flush", {63'h0, tlb_flush_all}, {63'h0, !f && fl});
            chk(tag, "not_busy", {63'h0, busy}, 64'h0);
            check_regs(tag);
        end
    endtask

    function automatic logic [31:0] pattern(input int p);
        case (p)
            0: return 32'h0000_0000;
            1: return 32'hE000_0011;
            2: return 32'h8000_0000;
            3: return 32'h0000_0020;
            4: return 32'h6000_0031;
            5: return 32'h0000_0800;
            6: return 32'h0000_00B0;
            default: return 32'h0123_4020;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();

        // sweep: every mode, privilege level, select and data pattern
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 4; c++)
                for (int s = 0; s < 4; s++)
                    for (int p = 0; p < 8; p++)
                        do_write(2'(s), pattern(p), 2'(c), 2'(m));

        // directed reload sequences
        do_reset();
        do_write(2'd0, 32'hE000_0011, 2'd0, 2'd1);   // R8: paging on, flush
        do_write(2'd2, 32'h0000_0020, 2'd0, 2'd1);   // R9: extension bit 5 rises
        inject_busy = 1'b1;
        do_write(2'd1, 32'h1234_5000, 2'd0, 2'd1);   // R9/R12: base write, junk while busy
        inject_busy = 1'b0;
        poison_idx = 2;
        do_write(2'd1, 32'h0ABC_0040, 2'd0, 2'd1);   // R11: bad entry
        poison_idx = 0;
        do_write(2'd1, 32'h0ABC_0060, 2'd0, 2'd0);   // R11: bad first entry, real mode
        poison_idx = -1;
        do_write(2'd0, 32'h6000_0011, 2'd0, 2'd1);   // R8: paging off
        do_write(2'd0, 32'hE000_0011, 2'd0, 2'd1);   // R9: paging rises with bit 5 set
        do_write(2'd0, 32'h0000_0020, 2'd0, 2'd0);   // R4: real mode skips combo check
        do_write(2'd2, 32'h0000_1000, 2'd3, 2'd0);   // R5: real mode reserved bit
        do_write(2'd1, 32'h5555_0000, 2'd0, 2'd3);   // R2: mode 3

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule